// File: doc/BRIEF.md
# Processor Reset Supervisor with Watchdog

This block drives the active-low reset line of a processor. Three things can start a reset cycle: supply voltage out of tolerance, a pushbutton on the reset line, and a watchdog that expires because software stopped toggling a strobe input. All timing is counted in ticks of a one-millisecond pulse (`ms_tick`). The reset pulse length and the watchdog base period are parameters, so a simulation can use short values.

The reset line is shared. The block pulls it low through `rst_drive`. It also reads the line's level back on `rst_pin_in`, so a pushbutton that grounds the line is seen on the same wire the block drives.

When the button is pressed, the block first produces a full pulse of its own. If the button is still held when that pulse ends, the block waits for the release and then produces a second full pulse.

The strobe, the reset-line level and the power-good level each pass through a two-flop synchronizer. A further flop after the synchronizer provides edge detection.

The state machine has six states:

- `ST_PWR_OFF`: supply bad, reset driven.
- `ST_HOLD`: the fixed reset pulse after power return, watchdog expiry or button release.
- `ST_PRESS`: the reset pulse started by a button press.
- `ST_SETTLE`: reset released; waits for the synchronizer to catch up before judging the line.
- `ST_WAIT_REL`: button still held, no drive.
- `ST_IDLE`: normal operation, watchdog running.

The transitions are:

- Supply-bad from any state goes to `ST_PWR_OFF`.
- `ST_PWR_OFF` goes to `ST_HOLD` when power is good.
- `ST_HOLD` goes to `ST_IDLE` at the end of the pulse.
- `ST_PRESS` goes to `ST_SETTLE` at the end of the pulse.
- `ST_SETTLE` goes to `ST_IDLE` if the line is high, or to `ST_WAIT_REL` if it is low.
- `ST_WAIT_REL` goes to `ST_HOLD` when the line rises.
- `ST_IDLE` goes to `ST_PRESS` on a falling edge of the line.
- `ST_IDLE` goes to `ST_HOLD` on watchdog expiry. A line falling edge wins if both happen in the same cycle.

Top module: `rst_supervisor`

## Requirements
- R1: After `rst_n` is released with `pwr_good` low, `rst_drive` and `busy` are both 1.
- R2: Whenever the synchronized `pwr_good` is low, `rst_drive` and `busy` are 1 on the next cycle. Any button or watchdog cycle in progress is abandoned.
- R3: After the synchronized `pwr_good` goes high, `rst_drive` stays 1 for exactly `HOLD_MS` ticks and is then released. `busy` falls with it.
- R4: In `ST_IDLE`, a falling edge of the synchronized reset line starts a drive of `HOLD_MS` ticks.
- R5: If the line is still low once that pulse has ended and `SYNC_STAGES+1` settle cycles have passed, `rst_drive` is 0 and `busy` is 1 until the line rises. The rise starts a further drive of `HOLD_MS` ticks.
- R6: If the line is high after the settle cycles, the block returns to `ST_IDLE` with `busy` at 0.
- R7: `wd_sel` selects the watchdog period: 2'b01 is `WD_BASE_MS` ticks, 2'b10 is twice that, and 2'b11 is four times that. When the period elapses in `ST_IDLE`, the block drives reset for `HOLD_MS` ticks.
- R8: With `wd_sel` = 2'b00 the watchdog never expires.
- R9: The watchdog counts only in `ST_IDLE`. A falling edge of the synchronized strobe restarts its count from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset of the logic |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| pwr_good | input | 1 | Supply-in-tolerance level from the comparator |
| rst_pin_in | input | 1 | Sensed level of the shared reset line |
| strobe_in | input | 1 | Watchdog restart strobe (falling edge restarts) |
| wd_sel | input | 2 | Watchdog period select (00 disables) |
| rst_drive | output | 1 | 1 pulls the reset line low |
| busy | output | 1 | 1 while a reset cycle is in progress |

## Verification
On every cycle, the assertions check four things:

- Supply loss always leads to drive.
- A line fall in `ST_IDLE` always starts a drive.
- A watchdog expiry always lands in `ST_HOLD`, and the watchdog counter stays clear outside `ST_IDLE` and after a strobe edge.
- A held button keeps the block in `ST_WAIT_REL`.

Some behaviour only the bench's scenarios against its reference model can show. This covers the exact pulse lengths in ticks, the three watchdog periods, and the two-pulse sequence of a long press. It also covers the restart of the hold after a power loss in the middle of a button or watchdog cycle.

// File: rtl/rsv_pkg.sv
package rsv_pkg;
    typedef enum logic [2:0] {
        ST_PWR_OFF,
        ST_HOLD,
        ST_PRESS,
        ST_SETTLE,
        ST_WAIT_REL,
        ST_IDLE
    } sv_state_e;

    localparam logic [1:0] WD_OFF = 2'b00;
    localparam logic [1:0] WD_X1  = 2'b01;
    localparam logic [1:0] WD_X2  = 2'b10;
    localparam logic [1:0] WD_X4  = 2'b11;
endpackage

// File: rtl/rsv_sync.sv
module rsv_sync #(
    parameter int          WIDTH   = 3,
    parameter int          STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] lvl,
    output logic [WIDTH-1:0] fall
);
    genvar i;
    generate
        for (i = 0; i < WIDTH; i++) begin : g_bit
            logic [STAGES:0] chain;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= {(STAGES+1){RST_VAL[i]}};
                else        chain <= {chain[STAGES-1:0], din[i]};
            end
            assign lvl[i]  = chain[STAGES-1];
            assign fall[i] = chain[STAGES] & ~chain[STAGES-1];
        end
    endgenerate
endmodule

// File: rtl/rsv_wdog.sv
module rsv_wdog
    import rsv_pkg::*;
#(
    parameter int BASE_MS = 250
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       run,
    input  logic       kick,
    input  logic [1:0] sel,
    output logic       expire
);
    localparam int CW = $clog2(4 * BASE_MS + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;
    logic          at_end;

    always_comb begin
        unique case (sel)
            WD_X1:   lim = CW'(BASE_MS);
            WD_X2:   lim = CW'(2 * BASE_MS);
            WD_X4:   lim = CW'(4 * BASE_MS);
            default: lim = CW'(4 * BASE_MS);
        endcase
    end

    assign at_end = (cnt >= lim - CW'(1));
    assign expire = run && !kick && tick && (sel != WD_OFF) && at_end;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          cnt <= '0;
        else if (!run || kick)               cnt <= '0;
        else if (tick && sel != WD_OFF)      cnt <= at_end ? '0 : cnt + CW'(1);
    end

    AST_WD_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == WD_OFF) |-> !expire); // R8
    AST_WD_KICK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        kick |=> (cnt == '0)); // R9
    AST_WD_IDLE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == '0)); // R9
endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor
    import rsv_pkg::*;
#(
    parameter int HOLD_MS     = 250,
    parameter int WD_BASE_MS  = 250,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ms_tick,
    input  logic       pwr_good,
    input  logic       rst_pin_in,
    input  logic       strobe_in,
    input  logic [1:0] wd_sel,
    output logic       rst_drive,
    output logic       busy
);
    localparam int SETTLE = SYNC_STAGES + 1;
    localparam int HMAX   = (HOLD_MS > SETTLE) ? HOLD_MS : SETTLE;
    localparam int HW     = $clog2(HMAX + 1);

    logic [2:0] s_lvl, s_fall;
    logic       pwr_lvl, pin_lvl, pin_fall, stb_fall, pwr_drop;
    logic       wd_expire;
    sv_state_e  state_q, state_d;
    logic [HW-1:0] hold_cnt;
    logic       hold_done, settle_done;

    rsv_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b110)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({strobe_in, rst_pin_in, pwr_good}),
        .lvl  (s_lvl),
        .fall (s_fall)
    );

    assign pwr_lvl  = s_lvl[0];
    assign pin_lvl  = s_lvl[1];
    assign pwr_drop = s_fall[0];
    assign pin_fall = s_fall[1];
    assign stb_fall = s_fall[2];

    rsv_wdog #(.BASE_MS(WD_BASE_MS)) u_wdog (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (ms_tick),
        .run   (state_q == ST_IDLE),
        .kick  (stb_fall),
        .sel   (wd_sel),
        .expire(wd_expire)
    );

    assign hold_done   = ms_tick && (hold_cnt == HW'(HOLD_MS - 1));
    assign settle_done = (hold_cnt == HW'(SETTLE - 1));

    always_comb begin
        state_d = state_q;
        if (!pwr_lvl) begin
            state_d = ST_PWR_OFF;
        end else begin
            unique case (state_q)
                ST_PWR_OFF:  state_d = ST_HOLD;
                ST_HOLD:     if (hold_done) state_d = ST_IDLE;
                ST_PRESS:    if (hold_done) state_d = ST_SETTLE;
                ST_SETTLE:   if (settle_done) state_d = pin_lvl ? ST_IDLE : ST_WAIT_REL;
                ST_WAIT_REL: if (pin_lvl) state_d = ST_HOLD;
                ST_IDLE: begin
                    if (pin_fall)       state_d = ST_PRESS;
                    else if (wd_expire) state_d = ST_HOLD;
                end
                default:     state_d = ST_PWR_OFF;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_PWR_OFF;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                       hold_cnt <= '0;
        else if (state_d != state_q)                      hold_cnt <= '0;
        else if ((state_q == ST_HOLD || state_q == ST_PRESS) && ms_tick)
                                                          hold_cnt <= hold_cnt + HW'(1);
        else if (state_q == ST_SETTLE)                    hold_cnt <= hold_cnt + HW'(1);
    end

    always_comb begin
        rst_drive = 1'b0;
        busy      = 1'b1;
        unique case (state_q)
            ST_PWR_OFF, ST_HOLD, ST_PRESS: rst_drive = 1'b1;
            ST_SETTLE, ST_WAIT_REL:        rst_drive = 1'b0;
            ST_IDLE:                       busy      = 1'b0;
            default:                       rst_drive = 1'b1;
        endcase
    end

    AST_PWR_LOW_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_lvl |=> (rst_drive && busy)); // R2
    AST_PWR_DROP_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_drop |=> (state_q == ST_PWR_OFF)); // R2
    AST_HOLD_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD) |-> (hold_cnt < HW'(HOLD_MS))); // R3
    AST_PRESS_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && pwr_lvl && pin_fall) |=> (rst_drive && state_q == ST_PRESS)); // R4
    AST_WAIT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_REL && pwr_lvl && !pin_lvl) |=> (state_q == ST_WAIT_REL && !rst_drive)); // R5
    AST_WD_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (wd_expire && pwr_lvl && !pin_fall) |=> (rst_drive && state_q == ST_HOLD)); // R7
endmodule

// File: tb/rst_supervisor_tb.sv
module rst_supervisor_tb;
    localparam int HOLD  = 6;
    localparam int BASE  = 5;
    localparam int SETTL = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ms_tick = 1'b0;
    logic pwr_good = 1'b0;
    logic btn = 1'b0;
    logic strobe_in = 1'b1;
    logic [1:0] wd_sel = 2'b11;
    logic rst_drive, busy;
    wire  rst_pin_in = ~(btn | rst_drive);

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;
    string cur_req = "R1";
    bit drive_seen = 1'b0;

    always #5 clk = ~clk;

    rst_supervisor #(.HOLD_MS(HOLD), .WD_BASE_MS(BASE), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .pwr_good(pwr_good),
        .rst_pin_in(rst_pin_in), .strobe_in(strobe_in), .wd_sel(wd_sel),
        .rst_drive(rst_drive), .busy(busy)
    );

    // reference model: 0 pwr off, 1 hold, 2 press, 3 settle, 4 wait, 5 idle
    int m_st = 0, m_h = 0, m_w = 0;
    bit p1, p2, p3, q1, q2, q3, s1, s2, s3;

    function automatic bit m_drive();
        return (m_st <= 2);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_h = 0; m_w = 0;
            {p1, p2, p3} = 3'b000; {q1, q2, q3} = 3'b111; {s1, s2, s3} = 3'b111;
        end else begin
            int nx, lim;
            bit pin_f, st_f, exp_w, pin_now;
            pin_f = q3 & ~q2;
            st_f  = s3 & ~s2;
            lim   = (wd_sel == 2'b01) ? BASE : (wd_sel == 2'b10) ? 2 * BASE : 4 * BASE;
            exp_w = (m_st == 5) && (wd_sel != 2'b00) && ms_tick && !st_f && (m_w >= lim - 1);
            nx = m_st;
            if (!p2) nx = 0;
            else if (m_st == 0) nx = 1;
            else if (m_st == 1) begin if (ms_tick && m_h == HOLD - 1) nx = 5; end
            else if (m_st == 2) begin if (ms_tick && m_h == HOLD - 1) nx = 3; end
            else if (m_st == 3) begin if (m_h == SETTL - 1) nx = q2 ? 5 : 4; end
            else if (m_st == 4) begin if (q2) nx = 1; end
            else begin
                if (pin_f) nx = 2;
                else if (exp_w) nx = 1;
            end
            if (m_st != 5 || st_f) m_w = 0;
            else if (ms_tick && wd_sel != 2'b00) m_w = (m_w >= lim - 1) ? 0 : m_w + 1;
            if (nx != m_st) m_h = 0;
            else if ((m_st == 1 || m_st == 2) && ms_tick) m_h++;
            else if (m_st == 3) m_h++;
            pin_now = ~(btn | m_drive());
            p3 = p2; p2 = p1; p1 = pwr_good;
            q3 = q2; q2 = q1; q1 = pin_now;
            s3 = s2; s2 = s1; s1 = strobe_in;
            m_st = nx;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        cyc++;
        if (rst_drive) drive_seen = 1'b1;
        if (rst_n) begin
            chk(rst_drive == m_drive(), {cur_req, " drive"}, rst_drive, m_drive());
            chk(busy == (m_st != 5), {cur_req, " busy"}, busy, m_st != 5);
        end
    end

    initial begin : tick_gen
        int d = 0;
        forever begin
            @(negedge clk);
            d = (d + 1) % 4;
            ms_tick = (d == 3);
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 3000 && busy; i++) @(negedge clk);
    endtask

    initial begin
        wait_cyc(3);
        rst_n = 1'b1;
        wait_cyc(2);
        chk(rst_drive && busy, "R1", {rst_drive, busy}, 3);

        cur_req = "R3";
        pwr_good = 1'b1;
        wait_cyc(8);
        chk(rst_drive == 1'b1, "R3", rst_drive, 1);
        wait_idle();
        chk(!rst_drive && !busy, "R3", {rst_drive, busy}, 0);

        cur_req = "R9";
        drive_seen = 1'b0;
        for (int k = 0; k < 12; k++) begin
            wait_cyc(36);
            strobe_in = 1'b0;
            wait_cyc(2);
            strobe_in = 1'b1;
        end
        chk(!drive_seen, "R9", drive_seen, 0);

        cur_req = "R7";
        drive_seen = 1'b0;
        wait_cyc(100);
        chk(drive_seen, "R7", drive_seen, 1);
        wait_idle();

        for (int s = 1; s <= 2; s++) begin
            wd_sel = s[1:0];
            drive_seen = 1'b0;
            wait_cyc(30 * s);
            chk(drive_seen, "R7", drive_seen, 1);
            wait_idle();
        end

        cur_req = "R8";
        wd_sel = 2'b00;
        wait_cyc(2);
        wait_idle();
        drive_seen = 1'b0;
        wait_cyc(400);
        chk(!drive_seen && !busy, "R8", {drive_seen, busy}, 0);

        cur_req = "R4";
        btn = 1'b1;
        wait_cyc(3);
        btn = 1'b0;
        wait_cyc(7);
        chk(rst_drive == 1'b1, "R4", rst_drive, 1);
        cur_req = "R6";
        wait_idle();
        wait_cyc(2);
        chk(!busy && !rst_drive, "R6", {rst_drive, busy}, 0);

        cur_req = "R5";
        btn = 1'b1;
        wait_cyc(45);
        chk(!rst_drive && busy, "R5", {rst_drive, busy}, 1);
        wait_cyc(20);
        chk(!rst_drive && busy, "R5", {rst_drive, busy}, 1);
        btn = 1'b0;
        wait_cyc(6);
        chk(rst_drive == 1'b1, "R5", rst_drive, 1);
        wait_idle();

        cur_req = "R2";
        btn = 1'b1;
        wait_cyc(3);
        btn = 1'b0;
        wait_cyc(8);
        pwr_good = 1'b0;
        wait_cyc(30);
        chk(rst_drive && busy, "R2", {rst_drive, busy}, 3);
        pwr_good = 1'b1;
        cur_req = "R3";
        wait_cyc(12);
        chk(rst_drive == 1'b1, "R3", rst_drive, 1);
        wait_idle();

        cur_req = "R2";
        wd_sel = 2'b01;
        drive_seen = 1'b0;
        wait_cyc(26);
        pwr_good = 1'b0;
        wait_cyc(10);
        chk(rst_drive && busy, "R2", {rst_drive, busy}, 3);
        pwr_good = 1'b1;
        wd_sel = 2'b00;
        wait_cyc(4);
        wait_idle();
        wait_cyc(5);
        chk(!busy, "R3", busy, 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        wait (cyc > 150000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: run did not finish, actual %0d expected 0", cyc);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule